// File: doc/BRIEF.md
# Synchronous FIFO with watermark flags

A single-clock first-in first-out buffer for smoothing variable-rate data transfers between two pieces of logic in the same clock domain. The word width and the address depth are parameters. The storage is a simple dual-port array with a registered read port, coded so that synthesis can map it to embedded block RAM. A write pointer and a read pointer index it and wrap around at the end of the array.

Alongside the data, the block reports how many words it holds, raises empty and full flags, and raises two watermark flags whose levels are parameters. A write while full or a read while empty is dropped and reported on an error output the following cycle. Read data is delivered one clock after the read is accepted.

Top module: `wm_fifo`

## Requirements
- R1: While `rst_n` is low, `level` is 0, `is_empty` and `near_empty` are 1, `is_full`, `near_full` and `bad_access` are 0, and `rd_data` is 0.
- R2: `is_empty` is 1 exactly when `level` is 0, and `is_full` is 1 exactly when `level` equals 2**ADDR_W. `level` is ADDR_W+1 bits wide so it can hold a full buffer.
- R3: `level` equals accepted writes minus accepted reads since reset: it rises by one after a lone accepted write and falls by one after a lone accepted read.
- R4: `near_full` is 1 when `level` >= AFULL_LEVEL, and `near_empty` is 1 when `level` <= AEMPTY_LEVEL.
- R5: Words leave in the order they were written. The word appears on `rd_data` at the first rising edge after the cycle in which the read is accepted, and `rd_data` holds its value in cycles with no accepted read.
- R6: A write while `is_full` is 1 is dropped: the stored words and `level` are unchanged by it, and the dropped word is never read out.
- R7: A read while `is_empty` is 1 is dropped: `level` stays 0 and `rd_data` keeps its previous value.
- R8: `bad_access` is 1 for exactly the cycle after a cycle with a dropped write or a dropped read, and 0 after any cycle without one. The legal half of a cycle that also carries a dropped access still takes effect.
- R9: A read and a write accepted in the same cycle leave `level` unchanged and move both pointers.
- R10: The pointers wrap around the array, so order and content are preserved over more than 2**ADDR_W words in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word read, valid one clock after an accepted read |
| level | output | ADDR_W+1 | Number of words held |
| is_empty | output | 1 | No words held |
| is_full | output | 1 | All 2**ADDR_W slots held |
| near_full | output | 1 | Level at or above AFULL_LEVEL |
| near_empty | output | 1 | Level at or below AEMPTY_LEVEL |
| bad_access | output | 1 | A write while full or a read while empty happened last cycle |

## Verification
The assertions assume that the watermark parameters satisfy AEMPTY_LEVEL < AFULL_LEVEL <= 2**ADDR_W, that `wr_en` and `rd_en` are never unknown once reset is released, and that reset is released away from a clock edge. The stimulus keeps the default parameters, drives every input on the falling edge so they are stable at each rising edge, and changes `rst_n` only on falling edges. Deliberately illegal accesses are part of the stimulus, since the flag and error assertions cover them.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;

  // Kind of access that takes effect in a cycle
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_PUSH = 2'b01,
    ACC_POP  = 2'b10,
    ACC_BOTH = 2'b11
  } acc_e;

  function automatic acc_e classify(input logic push_ok, input logic pop_ok);
    return acc_e'({pop_ok, push_ok});
  endfunction

endpackage

// File: rtl/wm_fifo_mem.sv
module wm_fifo_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Write port: no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Registered read port, holds when not reading
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/wm_fifo_ctrl.sv
module wm_fifo_ctrl
  import wm_fifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              full,
  input  logic              empty,
  output logic              wr_go,
  output logic              rd_go,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              err
);
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(1 << ADDR_W);

  // Named internal events
  logic wr_drop, rd_drop, bad_now;
  acc_e kind;

  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c,
                                                   input acc_e k);
    case (k)
      ACC_PUSH: return c + CNT_ONE;
      ACC_POP:  return c - CNT_ONE;
      default:  return c;
    endcase
  endfunction

  assign wr_go   = wr_en & ~full;
  assign rd_go   = rd_en & ~empty;
  assign wr_drop = wr_en & full;
  assign rd_drop = rd_en & empty;
  assign bad_now = wr_drop | rd_drop;
  assign kind    = classify(wr_go, rd_go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      err    <= 1'b0;
    end else begin
      if (wr_go) wr_ptr <= ptr_step(wr_ptr);
      if (rd_go) rd_ptr <= ptr_step(rd_ptr);
      cnt <= count_next(cnt, kind);
      err <= bad_now;
    end
  end

  // R2: occupancy never exceeds the array size
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

  // R3: occupancy moves by at most one word per cycle
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_ONE) || (cnt == $past(cnt) - CNT_ONE));

  // R6: a write while full leaves the write pointer where it was
  a_r6_full_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> (wr_ptr == $past(wr_ptr)));

  // R7: a read while empty leaves the read pointer where it was
  a_r7_empty_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> (rd_ptr == $past(rd_ptr)));

  // R10: pointers coincide only at empty or full
  a_r10_ptr_meet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == rd_ptr) |-> (empty || full));

endmodule

// File: rtl/wm_fifo_flags.sv
module wm_fifo_flags #(
  parameter int ADDR_W       = 4,
  parameter int AFULL_LEVEL  = 12,
  parameter int AEMPTY_LEVEL = 3,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full,
  output logic             afull,
  output logic             aempty
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << ADDR_W);
  localparam logic [CNT_W-1:0] AF_LVL  = CNT_W'(AFULL_LEVEL);
  localparam logic [CNT_W-1:0] AE_LVL  = CNT_W'(AEMPTY_LEVEL);

  function automatic logic at_least(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] lvl);
    return c >= lvl;
  endfunction

  function automatic logic at_most(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] lvl);
    return c <= lvl;
  endfunction

  assign empty  = (cnt == '0);
  assign full   = (cnt == CNT_MAX);
  assign afull  = at_least(cnt, AF_LVL);
  assign aempty = at_most(cnt, AE_LVL);

  // R2: never empty and full together
  a_r2_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R4: the watermarks bracket the hard limits
  a_r4_full_has_afull: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> afull);

  a_r4_empty_has_aempty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> aempty);

endmodule

// File: rtl/wm_fifo.sv
module wm_fifo #(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 4,
  parameter int AFULL_LEVEL  = 12,
  parameter int AEMPTY_LEVEL = 3,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  level,
  output logic              is_empty,
  output logic              is_full,
  output logic              near_full,
  output logic              near_empty,
  output logic              bad_access
);
  logic              wr_go, rd_go;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;

  wm_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .full   (is_full),
    .empty  (is_empty),
    .wr_go  (wr_go),
    .rd_go  (rd_go),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .cnt    (level),
    .err    (bad_access)
  );

  wm_fifo_flags #(
    .ADDR_W       (ADDR_W),
    .AFULL_LEVEL  (AFULL_LEVEL),
    .AEMPTY_LEVEL (AEMPTY_LEVEL)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (level),
    .empty  (is_empty),
    .full   (is_full),
    .afull  (near_full),
    .aempty (near_empty)
  );

  wm_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_go),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .re    (rd_go),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  // R8: an illegal access is reported the next cycle
  a_r8_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en && is_full) || (rd_en && is_empty)) |=> bad_access);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr_en && is_full) || (rd_en && is_empty)) |=> !bad_access);

  // R9: a legal read and write together keep the level
  a_r9_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !is_full && !is_empty) |=> $stable(level));

  // R5: output word only changes after an accepted read
  a_r5_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !is_empty) |=> $stable(rd_data));

endmodule

// File: tb/wm_fifo_test.sv
module wm_fifo_test;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 16;
  localparam int AF    = 12;
  localparam int AE    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [AW:0]   level;
  logic          is_empty, is_full, near_full, near_empty, bad_access;

  int n_chk = 0;
  int n_bad = 0;

  int          model[$];
  logic [DW-1:0] exp_dout = '0;
  logic          exp_err  = 1'b0;

  always #5 clk = ~clk;

  wm_fifo #(.DATA_W(DW), .ADDR_W(AW), .AFULL_LEVEL(AF), .AEMPTY_LEVEL(AE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .level(level), .is_empty(is_empty), .is_full(is_full),
    .near_full(near_full), .near_empty(near_empty), .bad_access(bad_access)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req);
    int sz = model.size();
    check("R3", {req, " level"}, int'(level), sz);
    check("R2", {req, " empty"}, int'(is_empty), int'(sz == 0));
    check("R2", {req, " full"}, int'(is_full), int'(sz == DEPTH));
    check("R4", {req, " near_full"}, int'(near_full), int'(sz >= AF));
    check("R4", {req, " near_empty"}, int'(near_empty), int'(sz <= AE));
    check("R8", {req, " bad_access"}, int'(bad_access), int'(exp_err));
    check("R5", {req, " rd_data"}, int'(rd_data), int'(exp_dout));
  endtask

  // One cycle: drive at falling edge, sample at next falling edge
  task automatic cyc(input logic we, input logic re, input logic [DW-1:0] d, input string req);
    logic w_ok = we && (model.size() < DEPTH);
    logic r_ok = re && (model.size() > 0);
    exp_err = (we && !w_ok) || (re && !r_ok);
    if (r_ok) exp_dout = DW'(model.pop_front());
    if (w_ok) model.push_back(int'(d));
    wr_en = we; rd_en = re; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_state(req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model.delete();
    exp_dout = '0;
    exp_err  = 1'b0;
    check("R1", "reset level", int'(level), 0);
    check("R1", "reset empty", int'(is_empty), 1);
    check("R1", "reset full", int'(is_full), 0);
    check("R1", "reset near_empty", int'(near_empty), 1);
    check("R1", "reset near_full", int'(near_full), 0);
    check("R1", "reset bad_access", int'(bad_access), 0);
    check("R1", "reset rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fill(input int base);
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b0, DW'(base + i), "R3 fill");
    check("R2", "full after fill", int'(is_full), 1);
  endtask

  task automatic t_overflow();
    cyc(1'b1, 1'b0, 8'hEE, "R6 write while full");
    check("R6", "level after dropped write", int'(level), DEPTH);
    cyc(1'b0, 1'b0, 8'h00, "R8 quiet after drop");
    cyc(1'b1, 1'b1, 8'hDD, "R8 read legal, write dropped");
    check("R8", "level after mixed", int'(level), DEPTH - 1);
  endtask

  task automatic t_drain();
    while (model.size() > 0) cyc(1'b0, 1'b1, 8'h00, "R5 drain order");
    check("R6", "empty after drain", int'(is_empty), 1);
  endtask

  task automatic t_underflow();
    cyc(1'b0, 1'b1, 8'h00, "R7 read while empty");
    check("R7", "rd_data held", int'(rd_data), int'(exp_dout));
    cyc(1'b0, 1'b0, 8'h00, "R7 idle");
    cyc(1'b1, 1'b1, 8'h5A, "R8 write legal, read dropped");
    check("R8", "level after write-with-bad-read", int'(level), 1);
    cyc(1'b0, 1'b0, 8'h00, "R5 hold idle");
    cyc(1'b0, 1'b1, 8'h00, "R5 read back");
    check("R5", "rd_data value", int'(rd_data), 8'h5A);
  endtask

  task automatic t_simul();
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, DW'(8'h30 + i), "R3 prefill");
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 1'b1, DW'(8'h60 + i), "R9 read and write");
      check("R9", "level steady", int'(level), 5);
    end
    t_drain();
  endtask

  task automatic t_watermark();
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b1, 1'b0, DW'(8'hC0 + i), "R4 rising");
      if (i + 1 == AE)     check("R4", "near_empty at level AE", int'(near_empty), 1);
      if (i + 1 == AE + 1) check("R4", "near_empty above AE", int'(near_empty), 0);
      if (i + 1 == AF - 1) check("R4", "near_full below AF", int'(near_full), 0);
      if (i + 1 == AF)     check("R4", "near_full at level AF", int'(near_full), 1);
    end
    t_drain();
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 3 * DEPTH; i++) begin
      cyc(1'b1, 1'b0, DW'(i * 7 + 1), "R10 wrap write");
      cyc(1'b1, 1'b0, DW'(i * 7 + 2), "R10 wrap write");
      cyc(1'b0, 1'b1, 8'h00, "R10 wrap read");
      if (model.size() >= DEPTH - 1) t_drain();
    end
    t_drain();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    t_reset();
    t_fill(8'hA0);
    t_overflow();
    t_drain();
    t_underflow();
    t_drain();
    t_simul();
    t_watermark();
    t_wrap();
    t_fill(8'h10);
    t_reset();
    cyc(1'b0, 1'b1, 8'h00, "R1 empty after reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule